// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This block drives three rail-enable flags from one enable request so that three supplies come up in a fixed order and go down in the opposite order. All timing is measured in periods of a slow timing tick, a one-cycle strobe in the system clock domain. When enable is asserted, rail 1 comes up first, then rail 2, then rail 3. When enable is removed, rail 3 goes down first, then rail 2, then rail 1.

The enable input can be asynchronous. It passes through a synchronizer before the controller acts on it. The first step in either direction waits for the next tick to set the tick phase. It then counts a further nine ticks, so the first delay is between nine and ten tick periods. Each later step waits exactly eight ticks after the previous flag change.

If enable drops before rail 1 has come up, the sequence is cancelled and nothing is driven. If enable drops part-way through power-up, the rails already up are taken down in reverse order. A static polarity select inverts all three flag outputs, for supplies whose enable input is active low.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, every flag is inactive, and busy and all_on are low.
- R2: After the synchronized enable rises, rail 1 becomes active on the ninth tick counted after the first tick that follows the rise. This gives a delay of 9 to 10 tick periods. A flag change becomes visible in the clock cycle after the tick strobe that causes it.
- R3: Rail 2 becomes active exactly 8 ticks after rail 1, and rail 3 exactly 8 ticks after rail 2. Exactly one rail changes per step.
- R4: When enable falls with all rails up, rail 3 goes inactive after the first delay (as in R2). Rail 2 follows 8 ticks later, and rail 1 after 8 more.
- R5: If enable falls before rail 1 is active, the pending delay is cancelled and busy drops. No flag changes, then or later.
- R6: If enable falls after rail 1 is active but before rail 3, power-up stops. After the first delay, the rails already active are turned off in reverse order, 8 ticks apart.
- R7: If enable returns during a power-down, the power-down still completes. A new power-up then begins from the first delay, and its first-delay phase tick is the first tick after the last rail goes off.
- R8: With invert_sel low, a flag is 1 when its rail is on. With invert_sel high, every flag output is inverted, so after reset all flags read 1.
- R9: busy is high while a delay is being counted and low when the rails are all off or all on. all_on is high only while all three rails are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing strobe, once per tick period |
| enable_in | input | 1 | Power request (asynchronous, synchronized inside the block) |
| invert_sel | input | 1 | Static polarity select: 0 active-high flags, 1 active-low flags |
| rail_flag | output | 3 | Rail enable flags; bit 0 is rail 1, bit 2 is rail 3 |
| busy | output | 1 | A sequencing delay is running |
| all_on | output | 1 | All rails are active |

## Verification
A scoreboard records the exact tick number of every expected flag change and compares it with the tick on which each change is observed. A design that counted eight or ten ticks for the first delay, or that counted the phase-setting tick as a real one, lands one tick off. The bench pulses enable for a few ticks and then checks that busy drops and that no flag ever moves; a design that kept counting after a short pulse would raise rail 1 late. It drops enable between rail 2 and rail 3, where a design that finished power-up or shut down from rail 3 would produce out-of-order changes. It re-raises enable during a power-down: a design that reversed at once, instead of finishing the power-down and starting again from the first delay, would show changes the scoreboard does not expect. A reset with inverted polarity then checks that the flags idle high and fall in order.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_RISE = 2'd1,
    PH_ON   = 2'd2,
    PH_FALL = 2'd3
  } phase_e;
endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rseq_delay.sv
module rseq_delay #(
  parameter int FIRST_TICKS = 9,
  parameter int STEP_TICKS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic first,
  input  logic cancel,
  output logic running,
  output logic expire
);
  localparam int MAXT = (FIRST_TICKS > STEP_TICKS) ? FIRST_TICKS : STEP_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] goal;

  assign expire = running && tick && !armed && (cnt == goal - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      goal    <= '0;
    end else if (start) begin
      running <= 1'b1;
      armed   <= first;
      cnt     <= '0;
      goal    <= first ? CW'(FIRST_TICKS) : CW'(STEP_TICKS);
    end else if (cancel) begin
      running <= 1'b0;
      armed   <= 1'b0;
    end else if (running && tick) begin
      if (armed)       armed   <= 1'b0;
      else if (expire) running <= 1'b0;
      else             cnt     <= cnt + CW'(1);
    end
  end

  // R2: the phase-setting tick is consumed only by a tick strobe
  a_r2_arm_by_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(armed) && !$past(start) && !$past(cancel)) |-> $past(tick));

  // R3: the count never passes its goal while running
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < goal));
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  localparam int LW = $clog2(NUM_RAILS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_s,
  input  logic          expire,
  output logic          start,
  output logic          first,
  output logic          cancel,
  output logic [LW-1:0] level,
  output phase_e        phase
);
  phase_e        ph_n;
  logic [LW-1:0] lvl_n;

  always_comb begin
    ph_n   = phase;
    lvl_n  = level;
    start  = 1'b0;
    first  = 1'b0;
    cancel = 1'b0;
    case (phase)
      PH_OFF: begin
        if (en_s) begin
          start = 1'b1;
          first = 1'b1;
          ph_n  = PH_RISE;
        end
      end
      PH_RISE: begin
        if (!en_s) begin
          if (level == '0) begin
            cancel = 1'b1;
            ph_n   = PH_OFF;
          end else begin
            start = 1'b1;
            first = 1'b1;
            ph_n  = PH_FALL;
          end
        end else if (expire) begin
          lvl_n = level + LW'(1);
          if (lvl_n == LW'(NUM_RAILS)) ph_n = PH_ON;
          else                         start = 1'b1;
        end
      end
      PH_ON: begin
        if (!en_s) begin
          start = 1'b1;
          first = 1'b1;
          ph_n  = PH_FALL;
        end
      end
      default: begin
        if (expire) begin
          lvl_n = level - LW'(1);
          if (lvl_n == '0) ph_n = PH_OFF;
          else             start = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OFF;
      level <= '0;
    end else begin
      phase <= ph_n;
      level <= lvl_n;
    end
  end

  // R9: steady phases sit at the end points of the level range
  a_r9_steady_levels: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_OFF) |-> (level == '0)) and
    ((phase == PH_ON)  |-> (level == LW'(NUM_RAILS))));

  // R3: level stays inside the rail count
  a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(NUM_RAILS));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int FIRST_TICKS = 9,
  parameter int STEP_TICKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 enable_in,
  input  logic                 invert_sel,
  output logic [NUM_RAILS-1:0] rail_flag,
  output logic                 busy,
  output logic                 all_on
);
  localparam int LW = $clog2(NUM_RAILS + 1);

  logic          en_sync;
  logic          t_start, t_first, t_cancel, t_running, t_expire;
  logic [LW-1:0] level;
  phase_e        phase;

  rseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(enable_in), .q(en_sync)
  );

  rseq_delay #(.FIRST_TICKS(FIRST_TICKS), .STEP_TICKS(STEP_TICKS)) u_delay (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start(t_start), .first(t_first), .cancel(t_cancel),
    .running(t_running), .expire(t_expire)
  );

  rseq_ctrl #(.NUM_RAILS(NUM_RAILS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_s(en_sync), .expire(t_expire),
    .start(t_start), .first(t_first), .cancel(t_cancel),
    .level(level), .phase(phase)
  );

  generate
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      assign rail_flag[i] = (level > LW'(i)) ^ invert_sel;
    end
  endgenerate

  assign busy   = t_running;
  assign all_on = (level == LW'(NUM_RAILS));

  // R2: flags move only on the cycle after a tick strobe
  a_r2_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> $past(tick));

  // R3: one rail per step
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |->
      ((level == $past(level) + LW'(1)) || (level + LW'(1) == $past(level))));

  // R5: rails only come up while the synchronized enable is high
  a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (level > $past(level)) |-> $past(en_sync));

  // R4: rails only go down during a falling sequence
  a_r4_fall_in_fall_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (level < $past(level)) |-> ($past(phase) == PH_FALL));

  // R9: busy agrees with the sequencing phase
  a_r9_busy_phase: assert property (@(posedge clk) disable iff (!rst_n)
    busy == ((phase == PH_RISE) || (phase == PH_FALL)));
endmodule

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
  localparam int TP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       enable_in = 1'b0;
  logic       invert_sel = 1'b0;
  logic [2:0] rail_flag;
  logic       busy, all_on;

  rail_sequencer i_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable_in(enable_in),
    .invert_sel(invert_sel), .rail_flag(rail_flag), .busy(busy), .all_on(all_on)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [2:0] val;
    int         tk;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         nchecks = 0;
  int         nerr = 0;
  int         tick_num = 0;
  bit         mon_on = 1'b0;
  bit         ended = 1'b0;
  logic [2:0] prev;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  endtask

  function automatic logic [2:0] img(input int lvl);
    logic [2:0] v = '0;
    for (int i = 0; i < lvl; i++) v[i] = 1'b1;
    return v ^ {3{invert_sel}};
  endfunction

  task automatic expect_lvl(input int lvl, input int tk, input string req);
    exp_t e;
    e.val = img(lvl);
    e.tk  = tk;
    e.req = req;
    sb.push_back(e);
  endtask

  // tick strobe: driven one time unit after the edge
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph++;
      if (ph == TP) begin
        ph = 0;
        tick = 1'b1;
        tick_num++;
      end else begin
        tick = 1'b0;
      end
    end
  end

  // monitor: pops expected changes and compares value and tick number
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rail_flag != prev) begin
        if (sb.size() == 0) begin
          check(1'b0, "unexpected flag change", int'(rail_flag), int'(prev));
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rail_flag == e.val, {e.req, " flag value"}, int'(rail_flag), int'(e.val));
          check(tick_num == e.tk, {e.req, " tick of change"}, tick_num, e.tk);
        end
        prev = rail_flag;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  // set enable a given number of cycles after a tick; returns that tick number
  task automatic set_en(input logic v, input int offset, output int base);
    int t;
    t = tick_num;
    while (tick_num == t) @(posedge clk);
    repeat (offset) @(negedge clk);
    enable_in = v;
    base = tick_num;
  endtask

  task automatic wait_tick(input int n);
    while (tick_num < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int b, c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev = rail_flag;
    check(rail_flag == 3'b000, "R1 flags after reset", int'(rail_flag), 0);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(all_on == 1'b0, "R1 all_on after reset", int'(all_on), 0);
    mon_on = 1'b1;

    // full power-up, enable early in the tick period
    set_en(1'b1, 2, b);
    expect_lvl(1, b + 10, "R2 rail1 up");
    expect_lvl(2, b + 18, "R3 rail2 up");
    expect_lvl(3, b + 26, "R3 rail3 up");
    wait_tick(b + 5);
    check(busy == 1'b1, "R9 busy during first delay", int'(busy), 1);
    check(all_on == 1'b0, "R9 all_on before complete", int'(all_on), 0);
    drain();
    check(all_on == 1'b1, "R9 all_on when complete", int'(all_on), 1);
    check(busy == 1'b0, "R9 busy idle when all on", int'(busy), 0);

    // full power-down, enable removed late in the tick period
    set_en(1'b0, 9, b);
    expect_lvl(2, b + 10, "R4 rail3 down");
    expect_lvl(1, b + 18, "R4 rail2 down");
    expect_lvl(0, b + 26, "R4 rail1 down");
    drain();
    check(busy == 1'b0, "R9 busy idle when all off", int'(busy), 0);
    check(all_on == 1'b0, "R9 all_on low when off", int'(all_on), 0);

    // glitch before rail 1: silent cancel
    set_en(1'b1, 2, b);
    wait_tick(b + 3);
    check(busy == 1'b1, "R9 busy while pulse pending", int'(busy), 1);
    enable_in = 1'b0;
    repeat (6) @(negedge clk);
    check(busy == 1'b0, "R5 busy cleared by early drop", int'(busy), 0);
    wait_tick(b + 18);
    check(rail_flag == img(0), "R5 flags untouched after pulse", int'(rail_flag), int'(img(0)));
    check(sb.size() == 0, "R5 no pending changes", sb.size(), 0);

    // abort between rail 2 and rail 3
    set_en(1'b1, 3, b);
    expect_lvl(1, b + 10, "R2 rail1 up before abort");
    expect_lvl(2, b + 18, "R3 rail2 up before abort");
    wait_tick(b + 19);
    set_en(1'b0, 2, c);
    expect_lvl(1, c + 10, "R6 rail2 down after abort");
    expect_lvl(0, c + 18, "R6 rail1 down after abort");
    drain();
    check(rail_flag == img(0), "R6 all off after abort", int'(rail_flag), int'(img(0)));

    // re-enable during power-down
    set_en(1'b1, 2, b);
    expect_lvl(1, b + 10, "R2 rail1 up");
    expect_lvl(2, b + 18, "R3 rail2 up");
    expect_lvl(3, b + 26, "R3 rail3 up");
    drain();
    set_en(1'b0, 2, c);
    expect_lvl(2, c + 10, "R4 rail3 down");
    wait_tick(c + 11);
    enable_in = 1'b1;
    expect_lvl(1, c + 18, "R7 power-down continues");
    expect_lvl(0, c + 26, "R7 power-down completes");
    expect_lvl(1, c + 36, "R7 fresh rail1 up");
    expect_lvl(2, c + 44, "R7 fresh rail2 up");
    expect_lvl(3, c + 52, "R7 fresh rail3 up");
    drain();
    check(all_on == 1'b1, "R7 all on after restart", int'(all_on), 1);

    // inverted polarity
    mon_on = 1'b0;
    rst_n = 1'b0;
    enable_in = 1'b0;
    invert_sel = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev = rail_flag;
    check(rail_flag == 3'b111, "R8 inverted flags after reset", int'(rail_flag), 7);
    mon_on = 1'b1;
    set_en(1'b1, 4, b);
    expect_lvl(1, b + 10, "R8 inverted rail1");
    expect_lvl(2, b + 18, "R8 inverted rail2");
    expect_lvl(3, b + 26, "R8 inverted rail3");
    drain();
    check(rail_flag == 3'b000, "R8 inverted flags all on", int'(rail_flag), 0);

    check(sb.size() == 0, "scoreboard empty at end", sb.size(), 0);
    finish_run();
  end
endmodule